// File: doc/BRIEF.md
# Delayed-Value Window Checker

This block watches one signal and enforces a fixed-latency rule: whenever an attempt is launched, the `value_i` input must be high exactly `DEPTH` clock edges later. An attempt can start on every clock edge, so up to `DEPTH` attempts can be in flight at the same time. All in-flight attempts are held in one packed vector that shifts by one position each clock. Bit position equals the attempt's age in cycles.

When an attempt reaches the end of its window, the checker compares `value_i` and produces a one-cycle pass or fail pulse. A 16-bit saturating counter tallies each kind of result. Two abort inputs, `abort_i` and `flush_i`, act by level. If either is high at any edge inside an attempt's window, that attempt is cancelled. This covers the launch edge, every interior edge and the judging edge. A result that has already been reported stays reported.

Top module: `delay_window_checker`

## Requirements
- R1: A synchronous active-low reset clears every in-flight attempt, both pulse outputs and both counters. No result appears for an attempt that was pending before the reset.
- R2: A launch sampled at clock edge k, with `value_i` high at edge k+DEPTH, gives `pass_o` high for exactly the one cycle after edge k+DEPTH.
- R3: A launch sampled at edge k, with `value_i` low at edge k+DEPTH, gives `fail_o` high for exactly the one cycle after edge k+DEPTH. With DEPTH=10, a launch at edge 0 and `value_i` low only at edge 10 gives exactly one failure.
- R4: An edge with `launch_i` low starts no attempt, so no result ever appears DEPTH edges later, whatever `value_i` is.
- R5: `abort_i` high at any edge from k to k+DEPTH cancels the attempt launched at edge k, so no result is reported for it. This includes a single-cycle pulse in the middle of the window.
- R6: `flush_i` has the same all-attempt cancelling effect as `abort_i`, at any edge of the window.
- R7: A failure already reported is never withdrawn. An abort that rises after the judging edge leaves both the fail pulse and the fail count unchanged.
- R8: Each pass pulse adds one to `pass_cnt_o` and each fail pulse adds one to `fail_cnt_o`, at the same edge that raises the pulse. Each counter stops at all ones (65535) and holds there.
- R9: Attempts launched on consecutive edges are judged independently. Each one uses only its own launch, its own window of aborts and the `value_i` at its own judging edge.
- R10: `pass_o` and `fail_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| launch_i | input | 1 | Starts a new attempt at this edge |
| value_i | input | 1 | Signal that must be high when an attempt ends |
| abort_i | input | 1 | Level abort; cancels all in-flight attempts |
| flush_i | input | 1 | Second level abort with the same effect |
| pass_o | output | 1 | One-cycle pulse: an attempt ended with value high |
| fail_o | output | 1 | One-cycle pulse: an attempt ended with value low |
| pass_cnt_o | output | CNT_W | Saturating count of pass pulses |
| fail_cnt_o | output | CNT_W | Saturating count of fail pulses |

## Verification
The hardest case to reach is an abort that lands strictly inside a window. Other attempts are overlapping it, and each of them has a different start edge, so the one pulse cancels some attempts and not others. Directed windows rebuild the ten-cycle single-failure scenario with a mid-window pulse, an abort on the launch edge, an abort on the judging edge and an abort after the judging edge. A long stretch then launches on every edge, with random values and sparse random aborts. In that stretch, a reference model that only uses the recorded stimulus history decides, for every edge, which attempt survives.

// File: rtl/dwc_pkg.sv
package dwc_pkg;

  // Outcome of the attempt whose window closes at the current edge
  typedef enum logic [1:0] {
    VERDICT_NONE = 2'd0,
    VERDICT_PASS = 2'd1,
    VERDICT_FAIL = 2'd2
  } verdict_e;

  // Number of distinct result kinds that get a counter
  localparam int unsigned RESULT_KINDS = 2;
  localparam int unsigned KIND_PASS    = 0;
  localparam int unsigned KIND_FAIL    = 1;

endpackage

// File: rtl/dwc_window.sv
// Packed in-flight attempt vector: bit i holds the attempt launched i+1 edges ago.
module dwc_window #(
  parameter int unsigned DEPTH = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             cancel_i,
  output logic [DEPTH-1:0] vec_o,
  output logic             due_o
);

  localparam int unsigned TOP = DEPTH - 1;

  logic [DEPTH-1:0] vec_q;
  logic             keep;
  logic             inject;

  // One shift, one entry bit, one replicated keep mask over the whole vector
  function automatic logic [DEPTH-1:0] advance(
    input logic [DEPTH-1:0] cur,
    input logic             entry,
    input logic             keep_all
  );
    logic [DEPTH-1:0] moved;
    moved    = cur << 1;
    moved[0] = entry;
    return moved & {DEPTH{keep_all}};
  endfunction

  assign keep   = ~cancel_i;
  assign inject = launch_i & keep;

  always_ff @(posedge clk) begin
    if (!rst_n) vec_q <= '0;
    else        vec_q <= advance(vec_q, inject, keep);
  end

  assign vec_o = vec_q;
  assign due_o = vec_q[TOP];

endmodule

// File: rtl/dwc_judge.sv
// Decides the outcome of the attempt at the top of the window and registers pulses.
module dwc_judge
  import dwc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic due_i,
  input  logic value_i,
  input  logic cancel_i,
  output logic pass_ev_o,
  output logic fail_ev_o,
  output logic pass_o,
  output logic fail_o
);

  verdict_e verdict;

  function automatic verdict_e judge(input logic due, input logic val, input logic cancel);
    if (!due || cancel) return VERDICT_NONE;
    return val ? VERDICT_PASS : VERDICT_FAIL;
  endfunction

  assign verdict   = judge(due_i, value_i, cancel_i);
  assign pass_ev_o = (verdict == VERDICT_PASS);
  assign fail_ev_o = (verdict == VERDICT_FAIL);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pass_o <= 1'b0;
      fail_o <= 1'b0;
    end else begin
      pass_o <= pass_ev_o;
      fail_o <= fail_ev_o;
    end
  end

endmodule

// File: rtl/dwc_sat_counter.sv
// Counter that stops at all ones.
module dwc_sat_counter #(
  parameter int unsigned WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bump_i,
  output logic [WIDTH-1:0] count_o
);

  localparam logic [WIDTH-1:0] CNT_MAX = '1;

  logic [WIDTH-1:0] count_q;

  function automatic logic [WIDTH-1:0] sat_step(input logic [WIDTH-1:0] cur, input logic bump);
    if (bump && (cur != CNT_MAX)) return cur + 1'b1;
    return cur;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= sat_step(count_q, bump_i);
  end

  assign count_o = count_q;

endmodule

// File: rtl/delay_window_checker.sv
module delay_window_checker
  import dwc_pkg::*;
#(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             launch_i,
  input  logic             value_i,
  input  logic             abort_i,
  input  logic             flush_i,
  output logic             pass_o,
  output logic             fail_o,
  output logic [CNT_W-1:0] pass_cnt_o,
  output logic [CNT_W-1:0] fail_cnt_o
);

  // Named internal events, visible to the bound checker
  logic             cancel_all;
  logic [DEPTH-1:0] win_vec;
  logic             win_due;
  logic             pass_ev;
  logic             fail_ev;

  logic [RESULT_KINDS-1:0] kind_ev;
  logic [CNT_W-1:0]        kind_cnt [RESULT_KINDS];

  assign cancel_all = abort_i | flush_i;

  dwc_window #(.DEPTH(DEPTH)) u_window (
    .clk      (clk),
    .rst_n    (rst_n),
    .launch_i (launch_i),
    .cancel_i (cancel_all),
    .vec_o    (win_vec),
    .due_o    (win_due)
  );

  dwc_judge u_judge (
    .clk       (clk),
    .rst_n     (rst_n),
    .due_i     (win_due),
    .value_i   (value_i),
    .cancel_i  (cancel_all),
    .pass_ev_o (pass_ev),
    .fail_ev_o (fail_ev),
    .pass_o    (pass_o),
    .fail_o    (fail_o)
  );

  assign kind_ev[KIND_PASS] = pass_ev;
  assign kind_ev[KIND_FAIL] = fail_ev;

  for (genvar g = 0; g < RESULT_KINDS; g++) begin : g_tally
    dwc_sat_counter #(.WIDTH(CNT_W)) u_cnt (
      .clk     (clk),
      .rst_n   (rst_n),
      .bump_i  (kind_ev[g]),
      .count_o (kind_cnt[g])
    );
  end

  assign pass_cnt_o = kind_cnt[KIND_PASS];
  assign fail_cnt_o = kind_cnt[KIND_FAIL];

endmodule

// File: rtl/dwc_chk.sv
module dwc_chk #(
  parameter int unsigned DEPTH = 10,
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             launch_i,
  input logic             value_i,
  input logic             abort_i,
  input logic             flush_i,
  input logic             pass_o,
  input logic             fail_o,
  input logic [CNT_W-1:0] pass_cnt_o,
  input logic [CNT_W-1:0] fail_cnt_o,
  input logic [DEPTH-1:0] win_vec
);

  localparam logic [CNT_W-1:0] CNT_TOP = '1;

  // R10
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass_o && fail_o));

  // R5
  abort_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    abort_i |=> (win_vec == '0) && !pass_o && !fail_o);

  // R6
  flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush_i |=> (win_vec == '0) && !pass_o && !fail_o);

  // R4
  no_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !launch_i |=> !win_vec[0]);

  // R2
  due_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vec[DEPTH-1] && value_i && !abort_i && !flush_i) |=> pass_o);

  // R3
  due_fail_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (win_vec[DEPTH-1] && !value_i && !abort_i && !flush_i) |=> fail_o);

  // R8
  pass_cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pass_o |-> (pass_cnt_o == $past(pass_cnt_o) + 1'b1) || ($past(pass_cnt_o) == CNT_TOP));

  // R8
  fail_cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fail_o |-> $stable(fail_cnt_o));

endmodule

bind delay_window_checker dwc_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_dwc_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .launch_i   (launch_i),
  .value_i    (value_i),
  .abort_i    (abort_i),
  .flush_i    (flush_i),
  .pass_o     (pass_o),
  .fail_o     (fail_o),
  .pass_cnt_o (pass_cnt_o),
  .fail_cnt_o (fail_cnt_o),
  .win_vec    (win_vec)
);

// File: tb/tb_delay_window_checker.sv
`timescale 1ns/1ps
module tb_delay_window_checker;

  localparam int DEPTH = 10;
  localparam int CNT_W = 16;
  localparam int CMAX  = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic launch_i = 1'b0, value_i = 1'b1, abort_i = 1'b0, flush_i = 1'b0;
  logic pass_o, fail_o;
  logic [CNT_W-1:0] pass_cnt_o, fail_cnt_o;

  always #5 clk = ~clk;

  delay_window_checker #(.DEPTH(DEPTH), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .launch_i(launch_i), .value_i(value_i),
    .abort_i(abort_i), .flush_i(flush_i), .pass_o(pass_o), .fail_o(fail_o),
    .pass_cnt_o(pass_cnt_o), .fail_cnt_o(fail_cnt_o)
  );

  typedef struct {
    bit    p;
    bit    f;
    int    pc;
    int    fc;
    string tag;
  } item_t;

  item_t sb_q[$];
  bit hist_l[int];
  bit hist_v[int];
  bit hist_x[int];
  int edge_no = 0;
  int exp_pc = 0, exp_fc = 0;
  int n_cmp = 0, n_bad = 0;
  bit finished = 1'b0;

  // Driver: sets inputs for the next edge and pushes the expected result of that edge
  task automatic drive(bit l, bit v, bit a, bit fl, bit rn, string tag);
    item_t it;
    int    k;
    bit    alive;
    @(negedge clk);
    launch_i = l; value_i = v; abort_i = a; flush_i = fl; rst_n = rn;
    hist_l[edge_no] = l;
    hist_v[edge_no] = v;
    hist_x[edge_no] = a | fl | ~rn;
    it.p = 1'b0; it.f = 1'b0; it.tag = tag;
    if (!rn) begin
      exp_pc = 0; exp_fc = 0;
    end else begin
      k = edge_no - DEPTH;
      alive = (k >= 0) && hist_l.exists(k) && hist_l[k];
      if (alive)
        for (int j = k; j <= edge_no; j++) if (hist_x[j]) alive = 1'b0;
      if (alive) begin
        if (v) begin it.p = 1'b1; if (exp_pc < CMAX) exp_pc++; end
        else   begin it.f = 1'b1; if (exp_fc < CMAX) exp_fc++; end
      end
    end
    it.pc = exp_pc; it.fc = exp_fc;
    sb_q.push_back(it);
    edge_no++;
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, tag);
  endtask

  // One launch at local cycle 0 over a window of DEPTH+2 edges
  task automatic window(int low_at, int abort_at, int flush_at, string tag);
    for (int i = 0; i <= DEPTH + 1; i++)
      drive(i == 0, i != low_at, i == abort_at, i == flush_at, 1'b1, tag);
  endtask

  // Monitor: pops the item for each edge and compares just after it
  always @(posedge clk) begin
    item_t it;
    #1;
    if (sb_q.size() != 0) begin
      it = sb_q.pop_front();
      n_cmp++;
      if (pass_o !== it.p || fail_o !== it.f ||
          int'(pass_cnt_o) != it.pc || int'(fail_cnt_o) != it.fc) begin
        n_bad++;
        $display("FAIL %s: pass=%0b fail=%0b pcnt=%0d fcnt=%0d expected pass=%0b fail=%0b pcnt=%0d fcnt=%0d",
                 it.tag, pass_o, fail_o, pass_cnt_o, fail_cnt_o, it.p, it.f, it.pc, it.fc);
      end
      if (pass_o === 1'b1 && fail_o === 1'b1) begin
        n_bad++;
        $display("FAIL R10: pass=1 fail=1 expected at most one high");
      end
    end
  end

  initial begin
    #2_000_000;
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    for (int i = 0; i < 3; i++) drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R1");
    idle(2, "R1");
    // R3: one failure, value low only at judging edge
    window(DEPTH, -1, -1, "R3");
    // R5: one-cycle abort mid-window suppresses that failure
    window(DEPTH, 5, -1, "R5");
    // R2: pass
    window(-1, -1, -1, "R2");
    // R6: flush mid-window
    window(DEPTH, -1, 3, "R6");
    // R5: abort on launch edge, and on judging edge
    window(DEPTH, 0, -1, "R5");
    window(DEPTH, DEPTH, -1, "R5");
    // R6: flush on judging edge
    window(DEPTH, -1, DEPTH, "R6");
    // R7: abort after the failure was reported
    window(DEPTH, DEPTH + 1, -1, "R7");
    idle(3, "R7");
    // R4: no launch, value low everywhere
    for (int i = 0; i <= DEPTH + 2; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R4");
    // R9: overlapping attempts, random values and sparse aborts
    for (int i = 0; i < 400; i++)
      drive(($urandom % 4) != 0, ($urandom % 3) != 0, ($urandom % 23) == 0,
            ($urandom % 29) == 0, 1'b1, "R9");
    // R1: reset with attempts in flight
    for (int i = 0; i < 4; i++) drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R1");
    for (int i = 0; i < 2; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    for (int i = 0; i <= DEPTH + 2; i++) drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, "R1");
    // R8: pass counter saturates, fail counter still moves
    for (int i = 0; i < CMAX + DEPTH + 20; i++) drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R8");
    for (int i = 0; i < 20; i++) drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R8");
    idle(DEPTH + 3, "R8");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule